// File: doc/BRIEF.md
# Sinc3 Bitstream Decimation Filter

This block turns the single-bit, density-coded output of an external sigma-delta modulator into 16-bit unsigned words. It generates the modulator clock itself by dividing the system clock with a programmable half-period count. It takes one data bit per modulator period, on the falling edge of that clock. The bit stream runs through a three-stage cascaded integrator-comb decimator with a fixed ratio of 256. Every 256 modulator periods, the comb result is scaled to 16 bits, clamped and presented with a one-cycle valid pulse.

The output code is offset binary and follows the ones density of the input as density × 65536. A stream with half of its bits set reads 32768. A stream of all zeros reads 0. A stream of all ones would reach 65536, so it is held at 65535. With a 200 MHz system clock and a half-period count of 10, the modulator runs at 10 MHz and words arrive at about 39 kHz.

The output stage is a small sequencer with four states: PRIME_A, PRIME_B, PRIME_C and STREAM. Reset enters PRIME_A. Each decimation tick (the end of a 256-sample period) moves PRIME_A to PRIME_B, PRIME_B to PRIME_C, and PRIME_C to STREAM. STREAM stays in STREAM on every later tick. A word is reported on the tick that leaves PRIME_C and on every tick in STREAM. The comb history is therefore fully primed before the first word appears.

Top module: `sinc3_decim`

## Requirements
- R1: A synchronous active-high `rst` clears the integrators, comb delays and counters, and returns the sequencer to PRIME_A. While reset is held, `mod_clk` is 0, `word_valid` is 0 and `word_out` is 0.
- R2: `mod_clk` stays high for exactly H system clock cycles and low for exactly H cycles. H is `half_period`, so the duty cycle is 50%.
- R3: The data bit is taken at the system clock edge on which `mod_clk` falls. A value that `mod_data` holds only during the first system cycle after a rising edge of `mod_clk` has no effect on the output.
- R4: After the first word, valid pulses are spaced exactly 256 modulator periods apart, which is 512·H system clock cycles.
- R5: For a periodic input whose period divides 256, every reported word equals density × 65536. For example, 50% gives 32768, 81.25% gives 53248 and 18.75% gives 12288.
- R6: An all-ones input gives 65535 (saturated, no wrap to 0). An all-zeros input gives 0.
- R7: After reset, the first `word_valid` comes 768 modulator samples later, within one modulator period. No valid pulse appears before that.
- R8: `word_valid` is high for exactly one system cycle per word. `word_out` holds its value between valid pulses.
- R9: A `half_period` of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_period | input | 8 | System cycles per modulator clock phase (0 acts as 1) |
| mod_data | input | 1 | Bit stream from the modulator |
| mod_clk | output | 1 | Generated modulator clock |
| word_out | output | 16 | Decimated offset-binary word |
| word_valid | output | 1 | One-cycle strobe marking a new word |

## Verification
A wrong integrator or comb state shows as a wrong word value. For a constant-density input, the error appears on the first reported word after the fault and persists for up to three words, until the comb history flushes. A wrong phase counter or sequencer state shows at the ports as a valid pulse that comes early, late or at an uneven spacing, and it is visible within one decimation period. A sampling-edge fault changes which bit is captured, so with a briefly corrupted data line the word value moves away from its density code at once.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
    typedef enum logic [1:0] {
        ST_PRIME_A = 2'd0,
        ST_PRIME_B = 2'd1,
        ST_PRIME_C = 2'd2,
        ST_STREAM  = 2'd3
    } prime_state_t;
endpackage

// File: rtl/sinc3_clkgen.sv
module sinc3_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] half_period,
    input  logic             mod_data,
    output logic             mod_clk,
    output logic             sample_en,
    output logic             sample_bit
);
    logic [DIV_W-1:0] hp_eff;
    logic [DIV_W-1:0] phase_cnt;
    logic             mclk_q;

    assign hp_eff  = (half_period == '0) ? DIV_W'(1) : half_period;
    assign mod_clk = mclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_cnt  <= '0;
            mclk_q     <= 1'b0;
            sample_en  <= 1'b0;
            sample_bit <= 1'b0;
        end else begin
            sample_en <= 1'b0;
            if (phase_cnt >= hp_eff - DIV_W'(1)) begin
                phase_cnt <= '0;
                mclk_q    <= ~mclk_q;
                if (mclk_q) begin
                    sample_en  <= 1'b1;
                    sample_bit <= mod_data;
                end
            end else begin
                phase_cnt <= phase_cnt + DIV_W'(1);
            end
        end
    end

    // R3: a bit is taken exactly when the modulator clock falls
    p_sample_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $fell(mclk_q)) |-> sample_en);
    p_fall_only_sample_r3: assert property (@(posedge clk) disable iff (rst)
        sample_en |-> $fell(mclk_q));
endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
    parameter int ORDER = 3,
    parameter int ACC_W = 25,
    parameter int PH_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_en,
    input  logic             sample_bit,
    output logic [ACC_W-1:0] acc_out,
    output logic             tick
);
    logic [ACC_W-1:0] acc  [ORDER];
    logic [ACC_W-1:0] feed [ORDER];
    logic [PH_W-1:0]  phase;

    assign feed[0] = {{(ACC_W-1){1'b0}}, sample_bit};

    for (genvar g = 0; g < ORDER; g++) begin : g_int
        logic [ACC_W-1:0] sum_q;
        if (g > 0) begin : g_link
            assign feed[g] = acc[g-1];
        end
        always_ff @(posedge clk) begin
            if (rst)            sum_q <= '0;
            else if (sample_en) sum_q <= sum_q + feed[g];
        end
        assign acc[g] = sum_q;
    end

    assign acc_out = acc[ORDER-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= sample_en && (phase == '1);
            if (sample_en) phase <= phase + PH_W'(1);
        end
    end

    // R4: a decimation tick follows a sample and starts a new period
    p_tick_after_sample_r4: assert property (@(posedge clk) disable iff (rst)
        tick |-> $past(sample_en));
    p_tick_phase_zero_r4: assert property (@(posedge clk) disable iff (rst)
        tick |-> (phase == '0));
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb
    import sinc3_pkg::*;
#(
    parameter int ORDER = 3,
    parameter int ACC_W = 25,
    parameter int OUT_W = 16,
    parameter int SHIFT = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [ACC_W-1:0] acc_in,
    output logic [OUT_W-1:0] word_out,
    output logic             word_valid
);
    localparam int SCL_W = ACC_W - SHIFT;

    logic [ACC_W-1:0] stage_in [ORDER+1];
    logic [SCL_W-1:0] scaled;
    logic [OUT_W-1:0] clamped;
    prime_state_t     state_q, state_d;
    logic             emit;

    assign stage_in[0] = acc_in;

    for (genvar g = 0; g < ORDER; g++) begin : g_comb
        logic [ACC_W-1:0] dly_q;
        always_ff @(posedge clk) begin
            if (rst)       dly_q <= '0;
            else if (tick) dly_q <= stage_in[g];
        end
        assign stage_in[g+1] = stage_in[g] - dly_q;
    end

    assign scaled  = stage_in[ORDER][ACC_W-1:SHIFT];
    assign clamped = (|scaled[SCL_W-1:OUT_W]) ? {OUT_W{1'b1}} : scaled[OUT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_PRIME_A;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (tick) begin
            unique case (state_q)
                ST_PRIME_A: state_d = ST_PRIME_B;
                ST_PRIME_B: state_d = ST_PRIME_C;
                ST_PRIME_C: state_d = ST_STREAM;
                ST_STREAM:  state_d = ST_STREAM;
            endcase
        end
    end

    assign emit = tick && ((state_q == ST_PRIME_C) || (state_q == ST_STREAM));

    always_ff @(posedge clk) begin
        if (rst) begin
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= emit;
            if (emit) word_out <= clamped;
        end
    end

    // R8: valid is a single-cycle strobe and the word holds between strobes
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);
    p_word_hold_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !word_valid) |-> $stable(word_out));
    // R7: no word leaves while the history is still priming
    p_no_early_word_r7: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> ($past(tick) && ($past(state_q) != ST_PRIME_A)
                        && ($past(state_q) != ST_PRIME_B)));
endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim #(
    parameter int RATIO_LOG2 = 8,
    parameter int ORDER      = 3,
    parameter int OUT_W      = 16,
    parameter int DIV_W      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] half_period,
    input  logic             mod_data,
    output logic             mod_clk,
    output logic [OUT_W-1:0] word_out,
    output logic             word_valid
);
    localparam int GAIN_LOG2 = ORDER * RATIO_LOG2;
    localparam int ACC_W     = GAIN_LOG2 + 1;
    localparam int SHIFT     = GAIN_LOG2 - OUT_W;

    logic             sample_en;
    logic             sample_bit;
    logic [ACC_W-1:0] acc_last;
    logic             tick;

    sinc3_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk        (clk),
        .rst        (rst),
        .half_period(half_period),
        .mod_data   (mod_data),
        .mod_clk    (mod_clk),
        .sample_en  (sample_en),
        .sample_bit (sample_bit)
    );

    sinc3_integ #(.ORDER(ORDER), .ACC_W(ACC_W), .PH_W(RATIO_LOG2)) u_integ (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample_en),
        .sample_bit(sample_bit),
        .acc_out   (acc_last),
        .tick      (tick)
    );

    sinc3_comb #(.ORDER(ORDER), .ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_comb (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .acc_in    (acc_last),
        .word_out  (word_out),
        .word_valid(word_valid)
    );

    // R1: outputs are quiet in the cycle after a reset edge
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!word_valid && !mod_clk && (word_out == '0)));
endmodule

// File: tb/sinc3_decim_bench.sv
module sinc3_decim_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  half_period = 8'd1;
    logic        mod_data = 1'b0;
    logic        mod_clk;
    logic [15:0] word_out;
    logic        word_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sinc3_decim u_sinc3_decim (
        .clk        (clk),
        .rst        (rst),
        .half_period(half_period),
        .mod_data   (mod_data),
        .mod_clk    (mod_clk),
        .word_out   (word_out),
        .word_valid (word_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // evenly spread bit for density k/16 at stream position idx
    function automatic logic dens_bit(input int k, input int idx);
        int p = idx % 16;
        return (((p + 1) * k) / 16 - (p * k) / 16) != 0;
    endfunction

    task automatic run_case(input int k, input int hp, input bit glitch);
        int hpe      = (hp == 0) ? 1 : hp;
        int expv     = (k * 4096 > 65535) ? 65535 : k * 4096;
        int falls    = 0;
        int idx      = 0;
        int nvalid   = 0;
        int last_v   = -1;
        int cyc      = 0;
        int runlen   = 0;
        int bad_len  = 0;
        int bad_hold = 0;
        bit seen     = 1'b0;
        bit gl       = 1'b0;
        logic prev_clk = 1'b0;
        logic prev_val = 1'b0;
        logic cur;
        logic [15:0] held = '0;

        half_period = hp[7:0];
        rst = 1'b1;
        mod_data = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!mod_clk && !word_valid && word_out == 16'd0, "R1 reset state",
            int'({mod_clk, word_valid, word_out}), 0);
        rst = 1'b0;
        cur = 1'b0;
        while (nvalid < 4) begin
            @(negedge clk);
            cyc++;
            if (mod_clk != prev_clk) begin
                if (seen && runlen != hpe) bad_len++;
                seen   = 1'b1;
                runlen = 1;
                if (mod_clk) begin
                    cur = dens_bit(k, idx);
                    idx++;
                    mod_data = glitch ? ~cur : cur;
                    gl = glitch;
                end else begin
                    falls++;
                end
            end else begin
                runlen++;
                if (gl) begin
                    mod_data = cur;
                    gl = 1'b0;
                end
            end
            prev_clk = mod_clk;
            if (word_valid) begin
                if (prev_val) bad_hold++;
                nvalid++;
                if (nvalid == 1)
                    chk(falls == 768 || falls == 769, "R7 first word after 768 samples", falls, 768);
                else
                    chk(cyc - last_v == 512 * hpe, "R4 word spacing", cyc - last_v, 512 * hpe);
                chk(int'(word_out) == expv, (k == 16 || k == 0) ? "R6 saturation/zero" :
                    (glitch ? "R3/R5 falling-edge sample value" : "R5 density code"),
                    int'(word_out), expv);
                last_v = cyc;
                held = word_out;
            end else if (nvalid > 0 && word_out != held) begin
                bad_hold++;
            end
            prev_val = word_valid;
        end
        chk(bad_len == 0, (hp == 0) ? "R9 zero half-period" : "R2 clock phase length", bad_len, 0);
        chk(bad_hold == 0, "R8 single pulse and held word", bad_hold, 0);
    endtask

    initial begin
        for (int k = 0; k <= 16; k++) run_case(k, 1, 1'b0);
        run_case(13, 3, 1'b1);  // 81.25% -> 53248
        run_case(3, 3, 1'b1);   // 18.75% -> 12288
        run_case(16, 3, 1'b1);
        run_case(12, 2, 1'b1);
        run_case(8, 0, 1'b0);   // R9
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule